// File: doc/BRIEF.md
# Packed Integer Lane ALU

This block is a single-stage vector integer datapath. Two 128-bit operands are treated as a row of equal-width integer lanes: sixteen bytes, eight halfwords or four words. A small opcode selects one operation, which is applied to every lane at once. The operations are wrapping addition, signed saturating addition, signed comparison that produces all-ones or all-zeros lane masks, full-width bitwise logic, and signed 16-bit multiplies that return either the low half, the high half, or pairwise sums of the products.

An issuing pipeline drives the operands, the opcode, the lane-size select and a compare condition together with an input valid strobe. The result and an output valid flag are registered and appear on the next clock edge. While no input is valid, the result register keeps its contents. Compare masks can be merged with later logic operations, because the logic operations ignore lane boundaries.

Top module: `simd_alu`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous clock edge. The result of an accepted operation is on `result_o` one clock after `in_valid` was high. An active-low `rst_n` clears `out_valid` and `result_o` to zero.
- R2: Opcode 0 (ADD) adds each lane modulo 2^W, where W comes from `lsize_i`: 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes. No carry passes from one lane into the next.
- R3: Opcode 1 (ADDS) adds signed 8-bit or 16-bit lanes and clamps overflow to 0x7F/0x80 or 0x7FFF/0x8000. With 32-bit lanes it wraps, as ADD does.
- R4: Opcode 2 (CMP) writes all ones to a lane when its condition holds and all zeros when it does not.
- R5: CMP compares lanes as signed values. `cond_i` selects the condition: 0 = A==B, 1 = A<B, 2 = A<=B, 3 = A!=B, 4 = !(A<B), 5 = !(A<=B). Codes 6 and 7 give all zeros.
- R6: Opcodes 3 (AND), 4 (ANDN, which is ~A & B), 5 (OR) and 6 (XOR) act on all 128 bits and do not depend on `lsize_i`.
- R7: Opcode 7 (MULLO) gives the low 16 bits, and opcode 8 (MULHI) the high 16 bits, of the signed product of each 16-bit lane pair, whatever `lsize_i` is.
- R8: Opcode 9 (MADD) multiplies signed 16-bit lanes and adds the products of halfwords 2i and 2i+1 into 32-bit lane i, modulo 2^32.
- R9: While `in_valid` is low, `result_o` holds its value no matter what the other inputs do. Opcodes 10 to 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid |
| op_i | input | 4 | Operation code |
| lsize_i | input | 2 | Lane size select |
| cond_i | input | 3 | Compare condition |
| opa_i | input | 128 | Operand A |
| opb_i | input | 128 | Operand B |
| out_valid | output | 1 | Result valid |
| result_o | output | 128 | Registered result |

## Verification
On every cycle, the assertions check the valid timing and the holding of the result when no input is valid. They also check that every compare lane is a full mask, that byte saturation never turns the sign of same-signed operands, and that an ANDN result never has a bit set where A was one. Lane isolation of carries, the exact clamp values, each of the six compare conditions, and the multiply halves and pair sums can only be shown by the bench's scenarios. Those scenarios compare every lane against a scalar model, using operands chosen to sit at lane boundaries and at overflow limits.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int unsigned DATA_W = 128;
  localparam int unsigned BYTES  = DATA_W / 8;
  localparam int unsigned HALVES = DATA_W / 16;
  localparam int unsigned WORDS  = DATA_W / 32;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDS  = 4'd1,
    OP_CMP   = 4'd2,
    OP_AND   = 4'd3,
    OP_ANDN  = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_MULLO = 4'd7,
    OP_MULHI = 4'd8,
    OP_MADD  = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LS_8  = 2'd0,
    LS_16 = 2'd1,
    LS_32 = 2'd2,
    LS_32B = 2'd3
  } lane_sz_e;

  function automatic logic cond_hit(input logic eq, input logic lt, input logic [2:0] cc);
    case (cc)
      3'd0:    cond_hit = eq;
      3'd1:    cond_hit = lt;
      3'd2:    cond_hit = lt | eq;
      3'd3:    cond_hit = ~eq;
      3'd4:    cond_hit = ~lt;
      3'd5:    cond_hit = ~(lt | eq);
      default: cond_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  lane_sz_e     lsize,
  input  logic         saturate,
  output logic [W-1:0] sum_o
);
  localparam int unsigned NB = W / 8;
  localparam int unsigned NH = W / 16;

  logic [NB-1:0] carry;
  logic [NB-1:0] cut;
  logic [W-1:0]  wrap_sum;
  logic [W-1:0]  sat8;
  logic [W-1:0]  sat16;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic       cin;
    logic [8:0] t;
    // a lane starts at this byte for the chosen lane size: stop the carry
    always_comb begin
      case (lsize)
        LS_8:    cut[k] = 1'b1;
        LS_16:   cut[k] = (k % 2) == 0;
        default: cut[k] = (k % 4) == 0;
      endcase
    end
    if (k == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_rest
      assign cin = cut[k] ? 1'b0 : carry[k-1];
    end
    assign t = {1'b0, a[8*k +: 8]} + {1'b0, b[8*k +: 8]} + {8'd0, cin};
    assign carry[k] = t[8];
    assign wrap_sum[8*k +: 8] = t[7:0];

    logic ovf8;
    assign ovf8 = (a[8*k+7] == b[8*k+7]) && (t[7] != a[8*k+7]);
    assign sat8[8*k +: 8] = ovf8 ? (a[8*k+7] ? 8'h80 : 8'h7F) : t[7:0];

    p_sat_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (saturate && lsize == LS_8 && a[8*k+7] == b[8*k+7]) |-> (sum_o[8*k+7] == a[8*k+7]))
      else $error("R3 byte saturation flipped sign");
  end

  for (genvar j = 0; j < NH; j++) begin : g_half
    logic ovf16;
    assign ovf16 = (a[16*j+15] == b[16*j+15]) && (wrap_sum[16*j+15] != a[16*j+15]);
    assign sat16[16*j +: 16] = ovf16 ? (a[16*j+15] ? 16'h8000 : 16'h7FFF)
                                     : wrap_sum[16*j +: 16];
  end

  always_comb begin
    if (!saturate) begin
      sum_o = wrap_sum;
    end else begin
      case (lsize)
        LS_8:    sum_o = sat8;
        LS_16:   sum_o = sat16;
        default: sum_o = wrap_sum;
      endcase
    end
  end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
  import simd_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  lane_sz_e     lsize,
  input  logic [2:0]   cc,
  output logic [W-1:0] mask_o
);
  localparam int unsigned NB = W / 8;
  localparam int unsigned NH = W / 16;
  localparam int unsigned NW = W / 32;

  logic [W-1:0] m8, m16, m32;

  for (genvar k = 0; k < NB; k++) begin : g_b
    logic hit;
    assign hit = cond_hit(a[8*k +: 8] == b[8*k +: 8],
                          $signed(a[8*k +: 8]) < $signed(b[8*k +: 8]), cc);
    assign m8[8*k +: 8] = {8{hit}};
  end
  for (genvar j = 0; j < NH; j++) begin : g_h
    logic hit;
    assign hit = cond_hit(a[16*j +: 16] == b[16*j +: 16],
                          $signed(a[16*j +: 16]) < $signed(b[16*j +: 16]), cc);
    assign m16[16*j +: 16] = {16{hit}};
  end
  for (genvar i = 0; i < NW; i++) begin : g_w
    logic hit;
    assign hit = cond_hit(a[32*i +: 32] == b[32*i +: 32],
                          $signed(a[32*i +: 32]) < $signed(b[32*i +: 32]), cc);
    assign m32[32*i +: 32] = {32{hit}};
  end

  always_comb begin
    case (lsize)
      LS_8:    mask_o = m8;
      LS_16:   mask_o = m16;
      default: mask_o = m32;
    endcase
  end
endmodule

// File: rtl/simd_mul16.sv
module simd_mul16
  import simd_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] madd_o
);
  localparam int unsigned NH = W / 16;
  localparam int unsigned NW = W / 32;

  logic signed [31:0] prod [NH];

  for (genvar j = 0; j < NH; j++) begin : g_lane
    assign prod[j] = $signed(a[16*j +: 16]) * $signed(b[16*j +: 16]);
    assign lo_o[16*j +: 16] = prod[j][15:0];
    assign hi_o[16*j +: 16] = prod[j][31:16];
  end
  for (genvar i = 0; i < NW; i++) begin : g_pair
    assign madd_o[32*i +: 32] = prod[2*i] + prod[2*i+1];
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op_i,
  input  logic [1:0]    lsize_i,
  input  logic [2:0]    cond_i,
  input  logic [127:0]  opa_i,
  input  logic [127:0]  opb_i,
  output logic          out_valid,
  output logic [127:0]  result_o
);
  localparam int unsigned NB = DATA_W / 8;

  lane_sz_e          lsize;
  logic              sat_sel;
  logic [DATA_W-1:0] add_res, cmp_res, lo_res, hi_res, madd_res;
  logic [DATA_W-1:0] result_d, result_q;
  logic              valid_d, valid_q;

  assign lsize   = lane_sz_e'(lsize_i);
  assign sat_sel = (op_i == OP_ADDS);

  simd_lane_adder #(.W(DATA_W)) u_add (
    .clk(clk), .rst_n(rst_n), .a(opa_i), .b(opb_i),
    .lsize(lsize), .saturate(sat_sel), .sum_o(add_res));

  simd_lane_cmp #(.W(DATA_W)) u_cmp (
    .a(opa_i), .b(opb_i), .lsize(lsize), .cc(cond_i), .mask_o(cmp_res));

  simd_mul16 #(.W(DATA_W)) u_mul (
    .a(opa_i), .b(opb_i), .lo_o(lo_res), .hi_o(hi_res), .madd_o(madd_res));

  // next state: the result register loads only on an accepted operation
  always_comb begin
    valid_d  = in_valid;
    result_d = result_q;
    if (in_valid) begin
      case (op_i)
        OP_ADD, OP_ADDS: result_d = add_res;
        OP_CMP:          result_d = cmp_res;
        OP_AND:          result_d = opa_i & opb_i;
        OP_ANDN:         result_d = ~opa_i & opb_i;
        OP_OR:           result_d = opa_i | opb_i;
        OP_XOR:          result_d = opa_i ^ opb_i;
        OP_MULLO:        result_d = lo_res;
        OP_MULHI:        result_d = hi_res;
        OP_MADD:         result_d = madd_res;
        default:         result_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q  <= valid_d;
      result_q <= result_d;
    end
  end

  assign out_valid = valid_q;
  assign result_o  = result_q;

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid)
    else $error("R1 valid not raised after input");

  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid)
    else $error("R1 valid raised without input");

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result_o))
    else $error("R9 result changed while idle");

  p_andn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i == OP_ANDN) |=> ((result_o & $past(opa_i)) == '0))
    else $error("R6 ANDN leaked an A bit");

  for (genvar k = 0; k < NB; k++) begin : g_mask_chk
    p_full_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_i == OP_CMP) |=>
        (result_o[8*k +: 8] == 8'h00 || result_o[8*k +: 8] == 8'hFF))
      else $error("R4 partial compare mask");
  end
endmodule

// File: tb/sim_simd_alu.sv
`timescale 1ns/1ps
module sim_simd_alu;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [3:0]   op_i;
  logic [1:0]   lsize_i;
  logic [2:0]   cond_i;
  logic [127:0] opa_i, opb_i;
  logic         out_valid;
  logic [127:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  simd_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
    .lsize_i(lsize_i), .cond_i(cond_i), .opa_i(opa_i), .opb_i(opb_i),
    .out_valid(out_valid), .result_o(result_o));

  function automatic longint lane_get(input logic [127:0] v, input int l, input int w);
    logic [127:0] t;
    longint x;
    t = v >> (l * w);
    x = longint'(t[31:0]);
    x = x & ((64'sd1 <<< w) - 1);
    if (x >= (64'sd1 <<< (w - 1))) x = x - (64'sd1 <<< w);
    return x;
  endfunction

  function automatic logic [127:0] lane_put(input logic [127:0] r, input int l, input int w,
                                            input longint x);
    logic [127:0] m;
    m = (128'd1 << w) - 128'd1;
    return r | ((128'(x) & m) << (l * w));
  endfunction

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [3:0] op, input logic [1:0] sz,
                                         input logic [2:0] cc);
    int w;
    logic [127:0] r;
    longint sa, sb, s, hi, lo;
    bit eq, lt, h;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    r = '0;
    case (op)
      4'd0, 4'd1, 4'd2: begin
        for (int l = 0; l < 128 / w; l++) begin
          sa = lane_get(a, l, w);
          sb = lane_get(b, l, w);
          if (op == 4'd2) begin
            eq = (sa == sb); lt = (sa < sb);
            case (cc)
              3'd0: h = eq;
              3'd1: h = lt;
              3'd2: h = lt || eq;
              3'd3: h = !eq;
              3'd4: h = !lt;
              3'd5: h = !(lt || eq);
              default: h = 0;
            endcase
            r = lane_put(r, l, w, h ? -64'sd1 : 64'sd0);
          end else begin
            s = sa + sb;
            if (op == 4'd1 && w < 32) begin
              hi = (64'sd1 <<< (w - 1)) - 1;
              lo = -(64'sd1 <<< (w - 1));
              if (s > hi) s = hi;
              if (s < lo) s = lo;
            end
            r = lane_put(r, l, w, s);
          end
        end
      end
      4'd3: r = a & b;
      4'd4: r = ~a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7, 4'd8: begin
        for (int l = 0; l < 8; l++) begin
          s = lane_get(a, l, 16) * lane_get(b, l, 16);
          r = lane_put(r, l, 16, (op == 4'd7) ? s : (s >>> 16));
        end
      end
      4'd9: begin
        for (int l = 0; l < 4; l++) begin
          s = lane_get(a, 2*l, 16) * lane_get(b, 2*l, 16)
            + lane_get(a, 2*l+1, 16) * lane_get(b, 2*l+1, 16);
          r = lane_put(r, l, 32, s);
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: drive at negedge, capture at posedge, sample at next negedge
  task automatic run_op(input string req, input logic [3:0] op, input logic [1:0] sz,
                        input logic [2:0] cc, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1; op_i = op; lsize_i = sz; cond_i = cc; opa_i = a; opb_i = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {127'd0, out_valid}, 128'd1);
    check(req, result_o, model(a, b, op, sz, cc));
  endtask

  localparam logic [127:0] P1 = 128'h7F80_FF01_7FFF_8000_FFFF_0001_8000_0000;
  localparam logic [127:0] P2 = 128'h0180_0101_0001_8000_0001_FFFF_8000_0001;
  localparam logic [127:0] P3 = 128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6978;
  localparam logic [127:0] P4 = 128'h1234_5679_9ABB_DEF0_F0E1_2D3C_4B5A_8000;

  task automatic t_reset;
    check("R1 reset valid", {127'd0, out_valid}, 128'd0);
    check("R1 reset result", result_o, 128'd0);
  endtask

  task automatic t_add;
    for (int s = 0; s < 3; s++) begin
      run_op("R2 add lanes", 4'd0, 2'(s), 3'd0, P1, P2);
      run_op("R2 add lanes", 4'd0, 2'(s), 3'd0, {128{1'b1}}, 128'h0001_0001_0001_0001_0001_0001_0001_0001);
    end
  endtask

  task automatic t_adds;
    for (int s = 0; s < 3; s++) begin
      run_op("R3 sat add", 4'd1, 2'(s), 3'd0, P1, P1);
      run_op("R3 sat add", 4'd1, 2'(s), 3'd0, P1, P2);
    end
    run_op("R3 sat add clamp", 4'd1, 2'd1, 3'd0, {8{16'h7FF0}}, {8{16'h0020}});
  endtask

  task automatic t_cmp;
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 8; c++)
        run_op("R4 R5 compare", 4'd2, 2'(s), 3'(c), P3, P4);
  endtask

  task automatic t_logic;
    for (int o = 3; o < 7; o++) begin
      run_op("R6 logic", 4'(o), 2'd0, 3'd0, P3, P4);
      run_op("R6 logic size-free", 4'(o), 2'd2, 3'd0, P3, P4);
    end
  endtask

  task automatic t_mul;
    for (int s = 0; s < 3; s++) begin
      run_op("R7 mul low", 4'd7, 2'(s), 3'd0, P1, P2);
      run_op("R7 mul high", 4'd8, 2'(s), 3'd0, P1, P2);
    end
    run_op("R7 mul high", 4'd8, 2'd1, 3'd0, P3, P4);
  endtask

  task automatic t_madd;
    run_op("R8 pair sum", 4'd9, 2'd1, 3'd0, P1, P2);
    run_op("R8 pair sum", 4'd9, 2'd1, 3'd0, P3, P4);
    run_op("R8 pair sum wrap", 4'd9, 2'd0, 3'd0, {8{16'h8000}}, {8{16'h8000}});
  endtask

  task automatic t_hold;
    logic [127:0] keep;
    run_op("R9 setup", 4'd6, 2'd0, 3'd0, P1, P3);
    keep = result_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op_i = 4'(i); opa_i = P4; opb_i = P2;
      @(negedge clk);
      check("R9 hold valid", {127'd0, out_valid}, 128'd0);
      check("R9 hold result", result_o, keep);
    end
    run_op("R9 unused opcode", 4'd12, 2'd0, 3'd0, P1, P2);
  endtask

  task automatic t_stream;
    @(negedge clk);
    in_valid = 1'b1; op_i = 4'd0; lsize_i = 2'd0; opa_i = P1; opb_i = P2;
    @(negedge clk);
    check("R1 stream first", result_o, model(P1, P2, 4'd0, 2'd0, 3'd0));
    op_i = 4'd9; opa_i = P3; opb_i = P4;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 stream second", result_o, model(P3, P4, 4'd9, 2'd0, 3'd0));
    check("R1 stream valid", {127'd0, out_valid}, 128'd1);
    @(negedge clk);
    check("R1 stream drop", {127'd0, out_valid}, 128'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_i = '0; lsize_i = '0; cond_i = '0;
    opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_adds();
    t_cmp();
    t_logic();
    t_mul();
    t_madd();
    t_hold();
    t_stream();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule